// File: doc/BRIEF.md
# Sleep Wake Source Configurator

This block prepares interrupt logic for a low-power entry and reports what woke the system on resume. On a sleep request it captures the main and extended wake masks with their "allowed" companions. It refuses the entry if no allowed source is left unmasked. Otherwise it drives a single register-write port through a fixed sequence, one write per cycle:

- rewrite the two pin-mode ports, demoting interrupt-mode pins whose wake source is masked to plain input;
- load both masks into the active mask registers;
- clear the three pending registers by writing back their current values;
- write zero to the clock-enable register.

It then waits for a wake event and reports, for each 32-bit group, the pending bits that are not masked.

The sequencer is a state machine with states IDLE, CHECK, PINCFG, MASK, CLEAR, SLEEP and WAKE. The transitions are:

- IDLE to CHECK on `sleep_req`.
- CHECK to IDLE with `sleep_abort` when the check fails, and CHECK to PINCFG when it passes.
- PINCFG to MASK after two writes.
- MASK to CLEAR after two writes.
- CLEAR to SLEEP after three writes.
- SLEEP performs the clock write with `sleep_ack`, then waits.
- SLEEP to WAKE on `wake_evt`.
- WAKE to IDLE while the wake cause is captured.

Top module: `sleep_wake_cfg`

## Requirements
- R1: After reset, `wr_en`, `sleep_ack`, `sleep_abort` and `wake_valid` are low.
- R2: A group allows wake when (mask AND allow) differs from allow. When neither group allows wake, a sleep request gives a one-cycle `sleep_abort`, with no register write and no `sleep_ack`. An all-zero allow value never allows wake.
- R3: When either group allows wake, the sleep request runs the full write sequence and `sleep_abort` stays low.
- R4: Pin p (0 to 15) has a 2-bit mode field at bits [2*(p mod 8)+1 : 2*(p mod 8)]. Pins 0 to 7 are in `pincfg_lo` and pins 8 to 15 are in `pincfg_hi`. Interrupt mode is 2 and input is 0. The wake bit of pin p is main mask bit p for p below 4, and extended mask bit p otherwise. A field equal to 2 with its wake bit set is written as 0. Every other field is written unchanged, zero-extended to 32 bits.
- R5: The writes come on consecutive cycles in this order of `wr_sel` codes: 0 pin-low port, 1 pin-high port, 2 main mask, 3 extended mask, 4 extended pending, 5 interrupt pending, 6 source pending, 7 clock enable. Each mask write carries the mask value captured at the request.
- R6: The three pending writes carry the current `ext_pend`, `int_pend` and `src_pend` values.
- R7: The clock-enable write carries 0, and `sleep_ack` is high in that same cycle.
- R8: A `wake_evt` while sleeping gives a one-cycle `wake_valid`, with `cause_main` = `src_pend` AND NOT main mask and `cause_ext` = `ext_pend` AND NOT extended mask.
- R9: A `wake_evt` outside the sleeping state has no effect: no `wake_valid` and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter sleep, sampled in IDLE |
| wake_evt | input | 1 | Wake event while sleeping |
| main_mask | input | 32 | Main wake mask (1 = masked) |
| main_allow | input | 32 | Main allowed sources |
| ext_mask | input | 32 | Extended wake mask (1 = masked) |
| ext_allow | input | 32 | Extended allowed sources |
| pincfg_lo | input | 16 | Current mode fields of pins 0 to 7 |
| pincfg_hi | input | 16 | Current mode fields of pins 8 to 15 |
| ext_pend | input | 32 | Current extended pending value |
| int_pend | input | 32 | Current interrupt pending value |
| src_pend | input | 32 | Current source pending value |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register select of the write |
| wr_data | output | 32 | Write data |
| sleep_ack | output | 1 | Sleep entered (clock gate written) |
| sleep_abort | output | 1 | Sleep refused, no wake source |
| wake_valid | output | 1 | Wake cause valid pulse |
| cause_main | output | 32 | Unmasked source-pending bits at wake |
| cause_ext | output | 32 | Unmasked extended-pending bits at wake |

## Verification
The ordering assertions assume that a sleep request is not issued again until the previous sequence has returned to IDLE. They also assume that `wake_evt` reaches the sleeping state only after the clock write. The bench waits for each sequence to finish and for the wake to be reported before its next request.

The wake-cause assertion takes the mask captured at the request as the reference. The bench therefore holds the mask inputs steady only between requests and may change the pending inputs freely before a wake.

// File: rtl/swc_pkg.sv
package swc_pkg;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_IN  = 2'd0;
    localparam logic [MODE_W-1:0] MODE_IRQ = 2'd2;

    typedef enum logic [2:0] {
        SEL_PIN_LO   = 3'd0,
        SEL_PIN_HI   = 3'd1,
        SEL_MAIN_MSK = 3'd2,
        SEL_EXT_MSK  = 3'd3,
        SEL_EXT_PND  = 3'd4,
        SEL_INT_PND  = 3'd5,
        SEL_SRC_PND  = 3'd6,
        SEL_CLK_EN   = 3'd7
    } wsel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PINCFG,
        ST_MASK,
        ST_CLEAR,
        ST_SLEEP,
        ST_WAKE
    } swc_state_t;

endpackage

// File: rtl/swc_wake_gate.sv
module swc_wake_gate #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] main_mask,
    input  logic [DATA_W-1:0] main_allow,
    input  logic [DATA_W-1:0] ext_mask,
    input  logic [DATA_W-1:0] ext_allow,
    output logic              can_sleep
);
    logic main_any;
    logic ext_any;

    // a group allows wake when some allowed bit is left unmasked
    assign main_any  = ((main_mask & main_allow) != main_allow);
    assign ext_any   = ((ext_mask & ext_allow) != ext_allow);
    assign can_sleep = main_any | ext_any;
endmodule

// File: rtl/swc_pin_demote.sv
module swc_pin_demote
    import swc_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int FLAT_W  = NUM_PINS * MODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAT_W-1:0]   cfg_in,
    input  logic [NUM_PINS-1:0] wake_bits,
    output logic [FLAT_W-1:0]   cfg_out
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [MODE_W-1:0] cur;
        logic [MODE_W-1:0] nxt;
        assign cur = cfg_in[p*MODE_W +: MODE_W];
        assign nxt = ((cur == MODE_IRQ) && wake_bits[p]) ? MODE_IN : cur;
        assign cfg_out[p*MODE_W +: MODE_W] = nxt;

        // R4: the only rewrite ever made is interrupt mode to input
        a_r4_only_demote: assert property (@(posedge clk) disable iff (!rst_n)
            (nxt != cur) |-> (cur == MODE_IRQ && nxt == MODE_IN));
    end
endmodule

// File: rtl/swc_wake_cause.sv
module swc_wake_cause #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] pend_main,
    input  logic [DATA_W-1:0] pend_ext,
    input  logic [DATA_W-1:0] mask_main,
    input  logic [DATA_W-1:0] mask_ext,
    output logic              valid,
    output logic [DATA_W-1:0] cause_main,
    output logic [DATA_W-1:0] cause_ext
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid      <= 1'b0;
            cause_main <= '0;
            cause_ext  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                cause_main <= pend_main & ~mask_main;
                cause_ext  <= pend_ext & ~mask_ext;
            end
        end
    end

    // R8: the report lasts exactly one cycle
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8: no reported bit is one the mask blocks
    a_r8_cause_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((cause_main & mask_main) == '0 && (cause_ext & mask_ext) == '0));
endmodule

// File: rtl/sleep_wake_cfg.sv
module sleep_wake_cfg
    import swc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PORT_PINS = 8,
    parameter int MAIN_PINS = 4,
    localparam int NUM_PINS = 2 * PORT_PINS,
    localparam int CFG_W    = PORT_PINS * MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic [DATA_W-1:0] main_mask,
    input  logic [DATA_W-1:0] main_allow,
    input  logic [DATA_W-1:0] ext_mask,
    input  logic [DATA_W-1:0] ext_allow,
    input  logic [CFG_W-1:0]  pincfg_lo,
    input  logic [CFG_W-1:0]  pincfg_hi,
    input  logic [DATA_W-1:0] ext_pend,
    input  logic [DATA_W-1:0] int_pend,
    input  logic [DATA_W-1:0] src_pend,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              sleep_ack,
    output logic              sleep_abort,
    output logic              wake_valid,
    output logic [DATA_W-1:0] cause_main,
    output logic [DATA_W-1:0] cause_ext
);
    swc_state_t state, state_nxt;
    logic [1:0] step, step_nxt;
    wsel_t      sel;

    logic [DATA_W-1:0] main_mask_q, main_allow_q, ext_mask_q, ext_allow_q;
    logic              can_sleep;
    logic [NUM_PINS-1:0]        wake_bits;
    logic [2*CFG_W-1:0]         cfg_new;
    logic                       capture;

    // capture the wake configuration when a request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_mask_q  <= '0;
            main_allow_q <= '0;
            ext_mask_q   <= '0;
            ext_allow_q  <= '0;
        end else if (state == ST_IDLE && sleep_req) begin
            main_mask_q  <= main_mask;
            main_allow_q <= main_allow;
            ext_mask_q   <= ext_mask;
            ext_allow_q  <= ext_allow;
        end
    end

    swc_wake_gate #(.DATA_W(DATA_W)) gate_i (
        .main_mask (main_mask_q),
        .main_allow(main_allow_q),
        .ext_mask  (ext_mask_q),
        .ext_allow (ext_allow_q),
        .can_sleep (can_sleep)
    );

    // low pin offsets take their wake bit from the main mask, the rest from the extended one
    assign wake_bits = {ext_mask_q[NUM_PINS-1:MAIN_PINS], main_mask_q[MAIN_PINS-1:0]};

    swc_pin_demote #(.NUM_PINS(NUM_PINS)) demote_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_in   ({pincfg_hi, pincfg_lo}),
        .wake_bits(wake_bits),
        .cfg_out  (cfg_new)
    );

    assign capture = (state == ST_WAKE);

    swc_wake_cause #(.DATA_W(DATA_W)) cause_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .pend_main (src_pend),
        .pend_ext  (ext_pend),
        .mask_main (main_mask_q),
        .mask_ext  (ext_mask_q),
        .valid     (wake_valid),
        .cause_main(cause_main),
        .cause_ext (cause_ext)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= 2'd0;
        end else begin
            state <= state_nxt;
            step  <= step_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        step_nxt  = step;
        unique case (state)
            ST_IDLE: begin
                step_nxt = 2'd0;
                if (sleep_req) state_nxt = ST_CHECK;
            end
            ST_CHECK: begin
                state_nxt = can_sleep ? ST_PINCFG : ST_IDLE;
            end
            ST_PINCFG: begin
                if (step == 2'd1) begin
                    state_nxt = ST_MASK;
                    step_nxt  = 2'd0;
                end else begin
                    step_nxt = step + 2'd1;
                end
            end
            ST_MASK: begin
                if (step == 2'd1) begin
                    state_nxt = ST_CLEAR;
                    step_nxt  = 2'd0;
                end else begin
                    step_nxt = step + 2'd1;
                end
            end
            ST_CLEAR: begin
                if (step == 2'd2) begin
                    state_nxt = ST_SLEEP;
                    step_nxt  = 2'd0;
                end else begin
                    step_nxt = step + 2'd1;
                end
            end
            ST_SLEEP: begin
                if (step == 2'd0) begin
                    step_nxt = 2'd1;
                end else if (wake_evt) begin
                    state_nxt = ST_WAKE;
                    step_nxt  = 2'd0;
                end
            end
            ST_WAKE: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
                step_nxt  = 2'd0;
            end
        endcase
    end

    // outputs
    always_comb begin
        wr_en       = 1'b0;
        sel         = SEL_PIN_LO;
        wr_data     = '0;
        sleep_ack   = 1'b0;
        sleep_abort = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_CHECK: sleep_abort = !can_sleep;
            ST_PINCFG: begin
                wr_en = 1'b1;
                if (step == 2'd0) begin
                    sel     = SEL_PIN_LO;
                    wr_data = {{(DATA_W-CFG_W){1'b0}}, cfg_new[CFG_W-1:0]};
                end else begin
                    sel     = SEL_PIN_HI;
                    wr_data = {{(DATA_W-CFG_W){1'b0}}, cfg_new[2*CFG_W-1:CFG_W]};
                end
            end
            ST_MASK: begin
                wr_en = 1'b1;
                if (step == 2'd0) begin
                    sel     = SEL_MAIN_MSK;
                    wr_data = main_mask_q;
                end else begin
                    sel     = SEL_EXT_MSK;
                    wr_data = ext_mask_q;
                end
            end
            ST_CLEAR: begin
                wr_en = 1'b1;
                if (step == 2'd0) begin
                    sel     = SEL_EXT_PND;
                    wr_data = ext_pend;
                end else if (step == 2'd1) begin
                    sel     = SEL_INT_PND;
                    wr_data = int_pend;
                end else begin
                    sel     = SEL_SRC_PND;
                    wr_data = src_pend;
                end
            end
            ST_SLEEP: begin
                if (step == 2'd0) begin
                    wr_en     = 1'b1;
                    sel       = SEL_CLK_EN;
                    wr_data   = '0;
                    sleep_ack = 1'b1;
                end
            end
            ST_WAKE: ;
            default: ;
        endcase
    end

    assign wr_sel = sel;

    // R5: the pin-high write directly follows the pin-low write
    a_r5_pin_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PIN_HI) |-> $past(wr_en && sel == SEL_PIN_LO));

    // R5: pending clears start right after the extended mask is loaded
    a_r5_mask_then_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EXT_PND) |-> $past(wr_en && sel == SEL_EXT_MSK));

    // R6: interrupt pending follows extended pending
    a_r6_int_after_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_INT_PND) |-> $past(wr_en && sel == SEL_EXT_PND));

    // R6: source pending follows interrupt pending
    a_r6_src_after_int: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SRC_PND) |-> $past(wr_en && sel == SEL_INT_PND));

    // R7: acknowledge comes right after the last pending clear
    a_r7_ack_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> $past(wr_en && sel == SEL_SRC_PND));

    // R2: a refused entry never coincides with acknowledge or a write
    a_r2_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_abort |-> (!sleep_ack && !wr_en));
endmodule

// File: tb/sleep_wake_cfg_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_cfg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_req = 1'b0, wake_evt = 1'b0;
    logic [31:0] main_mask = '0, main_allow = '0, ext_mask = '0, ext_allow = '0;
    logic [15:0] pincfg_lo = '0, pincfg_hi = '0;
    logic [31:0] ext_pend = '0, int_pend = '0, src_pend = '0;
    logic        wr_en, sleep_ack, sleep_abort, wake_valid;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data, cause_main, cause_ext;

    always #5 clk = ~clk;

    sleep_wake_cfg dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .main_mask(main_mask), .main_allow(main_allow),
        .ext_mask(ext_mask), .ext_allow(ext_allow),
        .pincfg_lo(pincfg_lo), .pincfg_hi(pincfg_hi),
        .ext_pend(ext_pend), .int_pend(int_pend), .src_pend(src_pend),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sleep_ack(sleep_ack), .sleep_abort(sleep_abort),
        .wake_valid(wake_valid), .cause_main(cause_main), .cause_ext(cause_ext)
    );

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, ack_cnt = 0, ack_at = -1, abort_cnt = 0, wv_cnt = 0;
    logic [2:0]  log_sel [16];
    logic [31:0] log_dat [16];
    logic [31:0] got_cm, got_ce;

    // observer, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && n_wr < 16) begin
                log_sel[n_wr] = wr_sel;
                log_dat[n_wr] = wr_data;
                if (sleep_ack) ack_at = n_wr;
                n_wr = n_wr + 1;
            end
            if (sleep_ack) ack_cnt = ack_cnt + 1;
            if (sleep_abort) abort_cnt = abort_cnt + 1;
            if (wake_valid) begin
                wv_cnt = wv_cnt + 1;
                got_cm = cause_main;
                got_ce = cause_ext;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1;
        n_wr = 0; ack_cnt = 0; ack_at = -1; abort_cnt = 0; wv_cnt = 0;
    endtask

    task automatic pulse_req();
        @(posedge clk); #1 sleep_req = 1'b1;
        @(posedge clk); #1 sleep_req = 1'b0;
        repeat (14) @(posedge clk);
        #1;
    endtask

    task automatic pulse_wake();
        @(posedge clk); #1 wake_evt = 1'b1;
        @(posedge clk); #1 wake_evt = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] exp_port(input logic [15:0] cfg, input int base,
                                             input logic [31:0] mm, input logic [31:0] em);
        logic [15:0] r = cfg;
        for (int i = 0; i < 8; i++) begin
            int p = base + i;
            logic wb = (p < 4) ? mm[p] : em[p];
            if (cfg[2*i +: 2] == 2'd2 && wb) r[2*i +: 2] = 2'd0;
        end
        return r;
    endfunction

    // checks a complete accepted sequence against the current inputs
    task automatic check_sequence(input string name);
        logic [2:0] exp_sel [8];
        logic [31:0] exp_dat [8];
        exp_sel = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
        exp_dat[0] = {16'h0, exp_port(pincfg_lo, 0, main_mask, ext_mask)};
        exp_dat[1] = {16'h0, exp_port(pincfg_hi, 8, main_mask, ext_mask)};
        exp_dat[2] = main_mask;
        exp_dat[3] = ext_mask;
        exp_dat[4] = ext_pend;
        exp_dat[5] = int_pend;
        exp_dat[6] = src_pend;
        exp_dat[7] = 32'h0;
        check(abort_cnt == 0, {"R3 no abort ", name}, abort_cnt, 0);
        check(n_wr == 8, {"R3 write count ", name}, n_wr, 8);
        for (int i = 0; i < 8; i++) begin
            if (i < n_wr) begin
                check(log_sel[i] == exp_sel[i], $sformatf("R5 sel %0d %s", i, name), log_sel[i], exp_sel[i]);
                if (i < 2)
                    check(log_dat[i] == exp_dat[i], $sformatf("R4 pin data %0d %s", i, name), log_dat[i], exp_dat[i]);
                else if (i < 4)
                    check(log_dat[i] == exp_dat[i], $sformatf("R5 mask data %0d %s", i, name), log_dat[i], exp_dat[i]);
                else if (i < 7)
                    check(log_dat[i] == exp_dat[i], $sformatf("R6 pend data %0d %s", i, name), log_dat[i], exp_dat[i]);
                else
                    check(log_dat[i] == exp_dat[i], {"R7 clock data ", name}, log_dat[i], exp_dat[i]);
            end
        end
        check(ack_cnt == 1 && ack_at == 7, {"R7 ack with clock write ", name}, ack_at, 7);
    endtask

    task automatic check_wake(input string name, input logic [31:0] np_src, input logic [31:0] np_ext);
        logic [31:0] mm = main_mask, em = ext_mask;
        src_pend = np_src; ext_pend = np_ext;
        clear_log();
        pulse_wake();
        check(wv_cnt == 1, {"R8 wake valid pulse ", name}, wv_cnt, 1);
        check(got_cm == (np_src & ~mm), {"R8 main cause ", name}, got_cm, np_src & ~mm);
        check(got_ce == (np_ext & ~em), {"R8 ext cause ", name}, got_ce, np_ext & ~em);
        check(n_wr == 0, {"R8 no write on wake ", name}, n_wr, 0);
    endtask

    task automatic t_reset();
        #1;
        check(!wr_en && !sleep_ack && !sleep_abort && !wake_valid, "R1 reset outputs",
              {28'h0, wr_en, sleep_ack, sleep_abort, wake_valid}, 32'h0);
    endtask

    task automatic t_abort_masked();
        main_mask = 32'hFFFF_FFFF; main_allow = 32'h0000_000F;
        ext_mask  = 32'hFFFF_FFFF; ext_allow  = 32'h0000_FFF0;
        clear_log();
        pulse_req();
        check(abort_cnt == 1, "R2 abort all masked", abort_cnt, 1);
        check(n_wr == 0 && ack_cnt == 0, "R2 no write or ack on abort", n_wr, 0);
    endtask

    task automatic t_abort_zero_allow();
        main_mask = 32'h0; main_allow = 32'h0;
        ext_mask  = 32'h0; ext_allow  = 32'h0;
        clear_log();
        pulse_req();
        check(abort_cnt == 1, "R2 abort zero allow", abort_cnt, 1);
        check(n_wr == 0, "R2 zero allow no write", n_wr, 0);
    endtask

    task automatic t_main_only();
        // pins: 0 irq masked(main), 1 irq unmasked, 2 output, 3 irq masked,
        // 4 irq masked(ext), 5 special masked, 6 irq unmasked, 7 input
        main_mask  = 32'hFFFF_FFF9 & ~32'h0000_0100;   // bit1,bit2 clear; bit8 clear
        main_allow = 32'h0000_0106;
        ext_mask   = 32'h0000_0030;
        ext_allow  = 32'h0;
        pincfg_lo  = {2'd0, 2'd2, 2'd3, 2'd2, 2'd2, 2'd1, 2'd2, 2'd2};
        pincfg_hi  = 16'hAAAA;
        ext_pend = 32'h1234_5678; int_pend = 32'h0F0F_0F0F; src_pend = 32'hCAFE_BABE;
        clear_log();
        pulse_req();
        check_sequence("main only");
        check_wake("main only", 32'h0000_0107, 32'h0000_00FF);
    endtask

    task automatic t_ext_only();
        // main bit4 set must not demote pin4; ext bit0 set must not demote pin0
        main_mask  = 32'hFFFF_FFF0 | 32'h0000_0010;
        main_allow = 32'h0000_00F0;
        ext_mask   = 32'h0000_A501;
        ext_allow  = 32'h0001_0000;
        pincfg_lo  = 16'hAAAA;
        pincfg_hi  = {2'd2, 2'd0, 2'd2, 2'd1, 2'd2, 2'd2, 2'd3, 2'd2};
        ext_pend = 32'h0001_FFFF; int_pend = 32'h8000_0001; src_pend = 32'h0;
        clear_log();
        pulse_req();
        check_sequence("ext only");
        check_wake("ext only", 32'hFFFF_FFFF, 32'h0001_A5FF);
    endtask

    task automatic t_wake_idle();
        clear_log();
        pulse_wake();
        check(wv_cnt == 0, "R9 wake in idle ignored", wv_cnt, 0);
        check(n_wr == 0 && ack_cnt == 0, "R9 no write from idle wake", n_wr, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_wake_idle();
        t_abort_masked();
        t_abort_zero_allow();
        t_main_only();
        t_ext_only();
        t_abort_masked();
        t_wake_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule